// File: doc/BRIEF.md
# Cross-Domain Oscillator Configuration Register Bank

This block sits on a simple register bus and holds the settings for a digitally tuned oscillator whose own logic runs on a second, unrelated clock. Software writes an enable bit, a frequency band, a trim (calibration) value and a coarse/fine tuning pair. Each accepted write is carried into the oscillator clock domain by a toggle request/acknowledge handshake. Each direction of the handshake crosses through a two-flop synchronizer. While a transfer is in flight the ready flag is low, and every configuration write is dropped without effect. Ready returns high only once the oscillator-domain registers hold the new settings. At that point the oscillator outputs may be used, and they run open-loop from the fields last transferred.

The values read over the bus are copies taken from the oscillator domain. A write does not refresh them. Only an explicit refresh request, or the transfer that follows reset, updates them, and they are valid once ready is high again. Each rise of ready latches an interrupt. The trim value is loaded from a fuse input after power-on. It is reloaded on a later reset only if software armed a reload by writing 0 to the trim-loaded bit. Both domains are assumed to leave reset together.

Top module: `osc_cfg_bank`

## Requirements
- R1: After power-on reset, `bus_ready` and `irq` are 0 and the trim-loaded bit (CTRL bit 31) reads 0. The trim is then loaded from `fuse_trim` and one transfer runs. After that, `bus_ready` is 1, `osc_trim` equals the fuse value and the trim-loaded bit reads 1.
- R2: A write to CTRL (address 0) or TUNE (address 1), or a refresh request (address 2 with bit 0 set), is accepted only while `bus_ready` is 1. It drives `bus_ready` to 0 on the next cycle. `bus_ready` returns to 1 only after the oscillator outputs carry the accepted value.
- R3: Any configuration write issued while `bus_ready` is 0 is discarded. It changes neither the oscillator outputs nor the readable copies.
- R4: Each 0-to-1 transition of `bus_ready` sets `irq`, and `irq` stays set until software clears it. Writing 1 to STATUS (address 3) bit 1 clears it, and a simultaneous ready rise takes priority over the clear.
- R5: In an accepted CTRL write whose bit 0 differs from the current enable, only the enable changes. Band, trim and the reload arming keep their values.
- R6: CTRL holds enable in bit 0, band in bits 5:4, trim in bits 15:8 and trim-loaded in bit 31. TUNE holds fine in bits 7:0 and coarse in bits 20:16. Every field can be rewritten while the oscillator is enabled, and `osc_*` follow it.
- R7: Reads of CTRL and TUNE return the copies taken from the oscillator domain at the most recent completed refresh request or post-reset transfer. A configuration write alone does not change them. A refresh write with bit 0 clear has no effect.
- R8: The band field is passed to `osc_band` unchanged. Code 0 is 96–150 MHz, code 1 is 50–110 MHz, code 2 is 25–55 MHz and code 3 is 20–30 MHz.
- R9: An accepted CTRL write that keeps the enable and has bit 31 at 0 arms a fuse reload. The trim-loaded bit then reads 0. The next reset reloads the trim from `fuse_trim`. Without arming, a reset that is not a power-on reset keeps the trim last written.
- R10: STATUS reads ready in bit 0 and `irq` in bit 1. A STATUS write is honoured even while `bus_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears trim and arms the fuse load |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_ready | output | 1 | Configuration is in the oscillator domain; writes accepted |
| irq | output | 1 | Latched ready-rise interrupt |
| fuse_trim | input | 8 | Factory trim value from fuses |
| osc_clk | input | 1 | Oscillator-domain clock |
| osc_rst_n | input | 1 | Synchronous active-low reset, oscillator domain |
| osc_en | output | 1 | Oscillator enable |
| osc_band | output | 2 | Frequency band code |
| osc_trim | output | 8 | Process trim value |
| osc_coarse | output | 5 | Coarse tuning |
| osc_fine | output | 8 | Fine tuning |

## Verification
The bench runs the two clocks at unrelated periods. It issues a second write one cycle after an accepted one, while ready is low. A design that let busy writes through would show those values on the oscillator outputs. A write that flips the enable carries different band and trim values, which a design merging the fields would pass on. The bench reads TUNE after a plain write and again after a refresh. It also clears the interrupt while a transfer is still in flight. Two warm resets, one armed and one not, with a changed fuse value, expose a trim that is reloaded when it should not be, or kept when a reload was armed.

// File: rtl/osc_cfg_pkg.sv
// Shared widths, register addresses, field positions and types for the
// oscillator configuration bank. Assumes a 32-bit register bus.
package osc_cfg_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int CAL_W    = 8;
    localparam int BAND_W   = 2;
    localparam int COARSE_W = 5;
    localparam int FINE_W   = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_TUNE = 2'd1;
    localparam logic [ADDR_W-1:0] A_SYNC = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int EN_BIT     = 0;
    localparam int BAND_LSB   = 4;
    localparam int TRIM_LSB   = 8;
    localparam int LOADED_BIT = 31;
    localparam int FINE_LSB   = 0;
    localparam int COARSE_LSB = 16;
    localparam int SYNC_BIT   = 0;
    localparam int RDY_BIT    = 0;
    localparam int IRQ_BIT    = 1;

    typedef struct packed {
        logic                en;
        logic [BAND_W-1:0]   band;
        logic [CAL_W-1:0]    trim;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } osc_cfg_t;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } bus_st_e;

    // Assemble the CTRL read word from a configuration copy.
    function automatic logic [DATA_W-1:0] pack_ctrl(osc_cfg_t c, logic loaded);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT]                  = c.en;
        w[BAND_LSB +: BAND_W]      = c.band;
        w[TRIM_LSB +: CAL_W]       = c.trim;
        w[LOADED_BIT]              = loaded;
        return w;
    endfunction

    // Assemble the TUNE read word from a configuration copy.
    function automatic logic [DATA_W-1:0] pack_tune(osc_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FINE_LSB +: FINE_W]      = c.fine;
        w[COARSE_LSB +: COARSE_W]  = c.coarse;
        return w;
    endfunction
endpackage

// File: rtl/osc_cfg_sync.sv
// Multi-flop synchronizer for a single level/toggle signal.
// Assumes the input changes at most once per several destination cycles.
module osc_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/osc_cfg_core.sv
// Oscillator-domain side of the handshake. It captures the bus-side settings
// when a new request toggle arrives, then answers by copying the toggle onto
// the acknowledge. Assumes cfg_i is held stable by the bus side until then.
module osc_cfg_core import osc_cfg_pkg::*; (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_s,
    input  osc_cfg_t cfg_i,
    output logic     ack_o,
    output osc_cfg_t cfg_o
);
    logic     ack_q;
    osc_cfg_t cfg_q;
    logic     take;

    assign take = (req_s != ack_q);

    // Latch the settings and acknowledge on each new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= cfg_i;
            ack_q <= req_s;
        end
    end

    assign ack_o = ack_q;
    assign cfg_o = cfg_q;

    AST_OSC_HOLDS_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cfg_o)) else $error("osc cfg moved without request"); // R2
endmodule

// File: rtl/osc_cfg_bus.sv
// Bus-domain side: register decode, configuration holding register, transfer
// sequencer, readable copies, fuse trim load/reload and the ready-rise
// interrupt. Assumes both clock domains leave reset together and ack_s is
// already synchronized into this domain.
module osc_cfg_bus import osc_cfg_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CAL_W-1:0]  fuse_trim,
    input  logic              ack_s,
    input  osc_cfg_t          osc_cfg_i,
    output logic              req_o,
    output osc_cfg_t          cfg_o,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              irq
);
    bus_st_e  st_q;
    osc_cfg_t cfg_q;
    osc_cfg_t rd_q;
    logic     req_q;
    logic     irq_q;
    logic     reload_q;
    logic     init_q;
    logic     refresh_q;

    logic any_rst;
    logic ctrl_wr, tune_wr, sync_wr, stat_clr;
    logic cfg_hit, accept, done, en_flip, loaded;

    // Decode the bus request and the handshake completion.
    always_comb begin
        any_rst  = !rst_n || !por_n;
        ctrl_wr  = wr && (addr == A_CTRL);
        tune_wr  = wr && (addr == A_TUNE);
        sync_wr  = wr && (addr == A_SYNC) && wdata[SYNC_BIT];
        stat_clr = wr && (addr == A_STAT) && wdata[IRQ_BIT];
        cfg_hit  = ctrl_wr || tune_wr || sync_wr;
        ready    = (st_q == ST_READY);
        accept   = ready && cfg_hit;
        done     = (st_q == ST_WAIT) && (ack_s == req_q);
        en_flip  = (wdata[EN_BIT] != cfg_q.en);
        loaded   = init_q && !reload_q;
    end

    // Sequence the initial load and each cross-domain transfer.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            st_q      <= ST_LOAD;
            req_q     <= 1'b0;
            refresh_q <= 1'b0;
            init_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_LOAD: begin
                    req_q     <= ~req_q;
                    refresh_q <= 1'b1;
                    st_q      <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (done) begin
                        st_q   <= ST_READY;
                        init_q <= 1'b1;
                    end
                end
                ST_READY: begin
                    if (accept) begin
                        req_q     <= ~req_q;
                        refresh_q <= sync_wr;
                        st_q      <= ST_WAIT;
                    end
                end
                default: st_q <= ST_LOAD;
            endcase
        end
    end

    // Hold the settings to be sent; trim and reload arming survive warm reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg_q    <= '0;
            reload_q <= 1'b1;
        end else if (!rst_n) begin
            cfg_q.en     <= 1'b0;
            cfg_q.band   <= '0;
            cfg_q.coarse <= '0;
            cfg_q.fine   <= '0;
        end else begin
            if ((st_q == ST_LOAD) && reload_q) begin
                cfg_q.trim <= fuse_trim;
                reload_q   <= 1'b0;
            end
            if (accept && ctrl_wr) begin
                if (en_flip) begin
                    cfg_q.en <= wdata[EN_BIT];
                end else begin
                    cfg_q.band <= wdata[BAND_LSB +: BAND_W];
                    cfg_q.trim <= wdata[TRIM_LSB +: CAL_W];
                    if (!wdata[LOADED_BIT]) reload_q <= 1'b1;
                end
            end
            if (accept && tune_wr) begin
                cfg_q.fine   <= wdata[FINE_LSB +: FINE_W];
                cfg_q.coarse <= wdata[COARSE_LSB +: COARSE_W];
            end
        end
    end

    // Refresh the readable copies from the oscillator domain on request.
    always_ff @(posedge clk) begin
        if (any_rst)                rd_q <= '0;
        else if (done && refresh_q) rd_q <= osc_cfg_i;
    end

    // Latch the interrupt on ready rise; software clears it via STATUS.
    always_ff @(posedge clk) begin
        if (any_rst)       irq_q <= 1'b0;
        else if (done)     irq_q <= 1'b1;
        else if (stat_clr) irq_q <= 1'b0;
    end

    // Return the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = pack_ctrl(rd_q, loaded);
            A_TUNE: rdata = pack_tune(rd_q);
            A_STAT: begin
                rdata[RDY_BIT] = ready;
                rdata[IRQ_BIT] = irq_q;
            end
            default: rdata = '0;
        endcase
    end

    assign req_o = req_q;
    assign cfg_o = cfg_q;
    assign irq   = irq_q;

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (any_rst)
        (ready && cfg_hit) |=> !ready) else $error("ready stayed high"); // R2
    AST_BUSY_FREEZES_CFG: assert property (@(posedge clk) disable iff (any_rst)
        (init_q && !ready) |=> $stable(cfg_q)) else $error("cfg changed while busy"); // R3
    AST_IRQ_ON_READY_RISE: assert property (@(posedge clk) disable iff (any_rst)
        $rose(ready) |-> irq) else $error("no irq on ready rise"); // R4
    AST_EN_FLIP_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (any_rst)
        (ready && ctrl_wr && en_flip) |=>
            (cfg_q.band == $past(cfg_q.band)) && (cfg_q.trim == $past(cfg_q.trim)))
        else $error("fields changed with enable"); // R5
    AST_COPY_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (any_rst)
        !(done && refresh_q) |=> $stable(rd_q)) else $error("copy moved"); // R7
endmodule

// File: rtl/osc_cfg_bank.sv
// Top level: bus-side register bank, oscillator-domain capture and the two
// toggle synchronizers between them. Assumes both resets are asserted
// together for several cycles of each clock.
module osc_cfg_bank import osc_cfg_pkg::*; (
    input  logic                bus_clk,
    input  logic                bus_rst_n,
    input  logic                por_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    output logic                irq,
    input  logic [CAL_W-1:0]    fuse_trim,
    input  logic                osc_clk,
    input  logic                osc_rst_n,
    output logic                osc_en,
    output logic [BAND_W-1:0]   osc_band,
    output logic [CAL_W-1:0]    osc_trim,
    output logic [COARSE_W-1:0] osc_coarse,
    output logic [FINE_W-1:0]   osc_fine
);
    logic     req_tgl, req_s, ack_tgl, ack_s;
    osc_cfg_t bus_cfg, core_cfg;
    logic     bus_rst_all_n;

    assign bus_rst_all_n = bus_rst_n && por_n;

    osc_cfg_bus u_bus (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .por_n     (por_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .fuse_trim (fuse_trim),
        .ack_s     (ack_s),
        .osc_cfg_i (core_cfg),
        .req_o     (req_tgl),
        .cfg_o     (bus_cfg),
        .rdata     (bus_rdata),
        .ready     (bus_ready),
        .irq       (irq)
    );

    osc_cfg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    osc_cfg_core u_core (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .req_s (req_s),
        .cfg_i (bus_cfg),
        .ack_o (ack_tgl),
        .cfg_o (core_cfg)
    );

    osc_cfg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_all_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign osc_en     = core_cfg.en;
    assign osc_band   = core_cfg.band;
    assign osc_trim   = core_cfg.trim;
    assign osc_coarse = core_cfg.coarse;
    assign osc_fine   = core_cfg.fine;
endmodule

// File: tb/osc_cfg_bank_tb.sv
`timescale 1ns/1ps
module osc_cfg_bank_tb;
    logic        bus_clk = 0, osc_clk = 0;
    logic        bus_rst_n = 1, por_n = 1, osc_rst_n = 1;
    logic [1:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_ready, irq;
    logic [7:0]  fuse_trim = 8'hA5;
    logic        osc_en;
    logic [1:0]  osc_band;
    logic [7:0]  osc_trim;
    logic [4:0]  osc_coarse;
    logic [7:0]  osc_fine;

    always #4   bus_clk = ~bus_clk;
    always #6.5 osc_clk = ~osc_clk;

    osc_cfg_bank u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .por_n(por_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq),
        .fuse_trim(fuse_trim), .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .osc_en(osc_en), .osc_band(osc_band), .osc_trim(osc_trim),
        .osc_coarse(osc_coarse), .osc_fine(osc_fine)
    );

    int n_chk = 0, n_err = 0;
    bit mon_en = 0, prev_rdy = 0;
    // reference model: applied settings, readable copies, flags
    bit       m_en, m_rld, m_irq;
    bit [1:0] m_band;
    bit [7:0] m_trim, m_fine;
    bit [4:0] m_coarse;
    bit       c_en;
    bit [1:0] c_band;
    bit [7:0] c_trim, c_fine;
    bit [4:0] c_coarse;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        logic [31:0] w = 0;
        case (a)
            2'd0: begin w[0] = c_en; w[5:4] = c_band; w[15:8] = c_trim; w[31] = !m_rld; end
            2'd1: begin w[7:0] = c_fine; w[20:16] = c_coarse; end
            2'd3: begin w[0] = 1'b1; w[1] = m_irq; end
            default: w = 0;
        endcase
        return w;
    endfunction

    // per-clock comparison against the model
    always @(negedge bus_clk) begin
        if (mon_en) begin
            if (bus_ready && !prev_rdy) m_irq = 1;
            prev_rdy = bus_ready;
            chk(irq == m_irq, "R4", "irq vs model", {31'b0, irq}, {31'b0, m_irq});
            if (bus_ready) begin
                chk({osc_en, osc_band, osc_trim, osc_coarse, osc_fine} ==
                    {m_en, m_band, m_trim, m_coarse, m_fine}, "R6", "osc outputs",
                    {8'b0, osc_en, osc_band, osc_trim, osc_coarse, osc_fine},
                    {8'b0, m_en, m_band, m_trim, m_coarse, m_fine});
                chk(bus_rdata == exp_read(bus_addr), "R7", "read copy",
                    bus_rdata, exp_read(bus_addr));
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, output bit acc);
        @(posedge bus_clk); #2;
        acc = bus_ready && (a < 2 || (a == 2 && d[0]));
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge bus_clk); #2;
        bus_wr = 0;
        if (acc) begin
            if (a == 0) begin
                if (d[0] != m_en) m_en = d[0];
                else begin
                    m_band = d[5:4]; m_trim = d[15:8];
                    if (!d[31]) m_rld = 1;
                end
            end else if (a == 1) begin
                m_fine = d[7:0]; m_coarse = d[20:16];
            end else begin
                c_en = m_en; c_band = m_band; c_trim = m_trim;
                c_coarse = m_coarse; c_fine = m_fine;
            end
        end
        if (a == 3 && d[1]) m_irq = 0;
    endtask

    task automatic wait_ready(input string req);
        bit seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge bus_clk);
            if (bus_ready) begin seen = 1; break; end
        end
        if (!seen) chk(0, req, "ready timeout", 0, 1);
    endtask

    task automatic do_reset(input bit power);
        mon_en = 0;
        bus_rst_n = 0; osc_rst_n = 0;
        if (power) por_n = 0;
        if (power || m_rld) m_trim = fuse_trim;
        m_rld = 0; m_en = 0; m_band = 0; m_coarse = 0; m_fine = 0; m_irq = 0;
        bus_addr = 0;
        repeat (6) @(posedge bus_clk);
        #2;
        chk(bus_ready == 0, "R1", "ready in reset", {31'b0, bus_ready}, 0);
        chk(irq == 0, "R1", "irq in reset", {31'b0, irq}, 0);
        chk(bus_rdata[31] == 0, "R1", "loaded bit in reset", {31'b0, bus_rdata[31]}, 0);
        por_n = 1; bus_rst_n = 1; osc_rst_n = 1;
        c_en = m_en; c_band = m_band; c_trim = m_trim; c_coarse = m_coarse; c_fine = m_fine;
        prev_rdy = 0; mon_en = 1;
        @(negedge bus_clk);
        chk(bus_ready == 0 && bus_rdata[31] == 0, "R1", "busy after release",
            {30'b0, bus_ready, bus_rdata[31]}, 0);
        wait_ready("R1");
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit acc;
        m_rld = 0;
        do_reset(1);
        chk(osc_trim == 8'hA5, "R1", "trim from fuse", {24'b0, osc_trim}, 32'hA5);
        @(negedge bus_clk);
        chk(bus_rdata[31] == 1, "R1", "loaded bit set", {31'b0, bus_rdata[31]}, 1);
        chk(irq == 1, "R4", "irq after init", {31'b0, irq}, 1);
        bus_write(3, 32'h2, acc);
        @(negedge bus_clk);
        chk(irq == 0, "R4", "irq cleared", {31'b0, irq}, 0);

        // accepted write, then writes while busy
        bus_write(1, 32'h000A_0033, acc);
        @(negedge bus_clk);
        chk(bus_ready == 0, "R2", "ready drops", {31'b0, bus_ready}, 0);
        bus_write(1, 32'h001F_00FF, acc);
        bus_write(0, 32'h8000_0001, acc);
        wait_ready("R2");
        chk(osc_coarse == 5'd10 && osc_fine == 8'h33, "R6", "tune applied",
            {19'b0, osc_coarse, osc_fine}, {19'b0, 5'd10, 8'h33});
        chk(osc_fine != 8'hFF && osc_en == 0, "R3", "busy writes dropped",
            {23'b0, osc_en, osc_fine}, {23'b0, 1'b0, 8'h33});
        bus_addr = 1;
        @(negedge bus_clk);
        chk(bus_rdata == 0, "R7", "copy stale before refresh", bus_rdata, 0);

        bus_write(2, 32'h1, acc);
        wait_ready("R7");
        bus_addr = 1;
        @(negedge bus_clk);
        chk(bus_rdata == 32'h000A_0033, "R7", "copy after refresh", bus_rdata, 32'h000A_0033);
        bus_write(2, 32'h0, acc);
        @(negedge bus_clk);
        chk(bus_ready == 1, "R7", "refresh bit clear ignored", {31'b0, bus_ready}, 1);

        // enable flip carries other fields that must be ignored
        bus_write(0, 32'h8000_1131, acc);
        wait_ready("R5");
        chk(osc_en == 1 && osc_band == 0 && osc_trim == 8'hA5, "R5", "enable alone",
            {21'b0, osc_en, osc_band, osc_trim}, {21'b0, 1'b1, 2'd0, 8'hA5});
        for (int b = 0; b < 4; b++) begin
            bus_write(0, 32'h8000_7701 | (b << 4), acc);
            wait_ready("R8");
            chk(osc_band == b[1:0] && osc_trim == 8'h77 && osc_en == 1, "R8", "band code",
                {22'b0, osc_band, osc_trim}, {22'b0, b[1:0], 8'h77});
        end
        bus_write(0, 32'h8000_0000, acc);
        wait_ready("R5");
        chk(osc_en == 0 && osc_band == 3, "R5", "disable alone",
            {29'b0, osc_en, osc_band}, {29'b0, 1'b0, 2'd3});

        // status write while busy
        bus_write(1, 32'h0001_0002, acc);
        bus_write(3, 32'h2, acc);
        @(negedge bus_clk);
        chk(bus_ready == 0 && irq == 0, "R10", "irq clear while busy",
            {30'b0, bus_ready, irq}, 0);
        wait_ready("R10");

        // warm reset without reload arming keeps written trim
        bus_write(0, 32'h8000_5510, acc);
        wait_ready("R9");
        fuse_trim = 8'h3C;
        do_reset(0);
        chk(osc_trim == 8'h55, "R9", "trim kept", {24'b0, osc_trim}, 32'h55);

        // arm reload, then warm reset reloads from fuse
        bus_write(0, 32'h0000_5510, acc);
        wait_ready("R9");
        bus_addr = 0;
        @(negedge bus_clk);
        chk(bus_rdata[31] == 0, "R9", "loaded bit after arm", {31'b0, bus_rdata[31]}, 0);
        do_reset(0);
        chk(osc_trim == 8'h3C, "R9", "trim reloaded", {24'b0, osc_trim}, 32'h3C);
        bus_addr = 0;
        @(negedge bus_clk);
        chk(bus_rdata[31] == 1, "R9", "loaded bit after reload", {31'b0, bus_rdata[31]}, 1);

        repeat (4) @(negedge bus_clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule